// File: doc/BRIEF.md
# Thread Criticality Accumulator

This block measures how much each hardware thread limits the progress of a parallel program. Every thread raises single-cycle "start working" and "stop working" pulses as it leaves or enters a wait. The block keeps one working flag per thread, a count of the working threads, and a timer that counts clock cycles since the last serviced event. At each serviced event, the elapsed interval is divided by the number of threads that were working. The integer quotient is added to the 64-bit score of every thread that was working. The working state is then updated. Over a measurement window the scores sum to roughly the elapsed time, and a thread that works while others wait collects the largest share.

A pulse is captured only while `busy_o` is low. Pulses that arrive in the same cycle wait in a small pending set and are serviced one at a time, lowest thread index first. The division is a bit-serial divider that runs for TW cycles. A window-clear input zeroes all scores and the timer. A load port and a read port let an operating system save and restore the score of a thread that is switched onto a hardware context.

Top module: `thread_crit_acc`

## Requirements
- R1: After reset all scores read zero, no thread is working (`active_o` = 0, `nactive_o` = 0) and `busy_o` is low.
- R2: Servicing a start pulse sets bit i of `active_o` and raises `nactive_o` by one. Servicing a stop pulse clears bit i and lowers `nactive_o` by one. `nactive_o` always equals the number of set bits in `active_o`.
- R3: At each serviced event, floor(interval / `nactive_o`) is added to the score of every thread whose flag was set before the event. The scores of threads that were not working do not change.
- R4: The interval is the timer value at service start. The timer is zeroed at each service start and by the window clear, counts one per clock after that, and saturates at 2^TW-1. A serviced event that starts at clock edge t, after a zeroing at edge r, therefore sees an interval of t-r-1.
- R5: When no thread is working at service start, no score changes. The state update happens at the service-start edge itself.
- R6: Pulses captured in the same cycle are serviced in ascending thread index. A thread that pulses start and stop in the same cycle is left unchanged.
- R7: A start pulse for a working thread, or a stop pulse for an idle thread, is ignored. It does not raise `busy_o`, does not change `active_o`, `nactive_o` or any score, and does not restart the timer.
- R8: `busy_o` is high from the cycle after a capture until the last pending event is applied. Pulses presented while `busy_o` is high are ignored.
- R9: A service with at least one working thread applies its shares and state update TW+1 cycles after service start. The next pending event starts on the following edge.
- R10: `win_clr` zeroes every score and the timer on the next edge. It takes priority over a load and an addition in the same cycle.
- R11: `ld_en` writes `ld_val` into the score of thread `ld_sel` on the next edge, and later additions build on the loaded value. `rd_val` shows the score of thread `rd_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_on_ev | input | NT | Per-thread start-working pulse |
| thr_off_ev | input | NT | Per-thread stop-working pulse |
| busy_o | output | 1 | High while events are pending or being serviced |
| active_o | output | NT | Working flag per thread |
| nactive_o | output | NW | Number of working threads |
| win_clr | input | 1 | Start of a measurement window: zero scores and timer |
| rd_sel | input | IW | Thread whose score is shown on rd_val |
| rd_val | output | CW | Score of thread rd_sel |
| ld_en | input | 1 | Write ld_val into the score of ld_sel |
| ld_sel | input | IW | Thread whose score is loaded |
| ld_val | input | CW | Value to load |

## Verification
The bench aims at the service ordering of simultaneous pulses. The shares depend on that order, so a design that picked the highest index first, or merged the events, would leave different scores in every thread. It checks the first event after an idle period, where a design that divided by a zero count or skipped the state update would corrupt a score or lose the start. It times the busy window exactly, which exposes a divider that is one cycle short or long, and a timer that restarts at apply time rather than service start. It also sends redundant pulses and a start-plus-stop pair for one thread. A design that accepted these would miscount `nactive_o` or restart the timer, and the next share would come out wrong.

// File: rtl/crit_pkg.sv
// Shared types for the thread criticality accumulator.
// Assumes nothing beyond the standard language.
package crit_pkg;
    // Service sequencer states: waiting for work, or waiting on the divider.
    typedef enum logic {SV_IDLE, SV_DIV} svc_state_t;
endpackage

// File: rtl/crit_div.sv
// Bit-serial restoring divider: quotient = floor(dvd_i / dvs_i).
// Assumes dvs_i is nonzero when start is pulsed. The result is valid while
// done is high, exactly DW cycles after the start edge, and done lasts one
// cycle.
module crit_div #(
    parameter int DW = 32,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dvd_i,
    input  logic [SW-1:0] dvs_i,
    output logic          done,
    output logic [DW-1:0] quo
);
    localparam int KW = $clog2(DW + 1);

    logic [SW-1:0] rem_q;
    logic [DW-1:0] quo_q;
    logic [SW-1:0] dvs_q;
    logic [DW-1:0] dvd_q;
    logic [KW-1:0] k_q;
    logic          run_q;
    logic [SW:0]   trial;
    logic [SW:0]   diff;
    logic          fits;

    // Trial subtraction for the current quotient bit.
    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = trial >= {1'b0, dvs_q};
    end

    // Load the operands on start, then retire one quotient bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            dvd_q <= '0;
            k_q   <= '0;
            run_q <= 1'b0;
        end else if (start) begin
            rem_q <= '0;
            quo_q <= dvd_i;
            dvs_q <= dvs_i;
            dvd_q <= dvd_i;
            k_q   <= KW'(DW);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (k_q != '0) begin
                rem_q <= fits ? diff[SW-1:0] : trial[SW-1:0];
                quo_q <= {quo_q[DW-2:0], fits};
                k_q   <= k_q - 1'b1;
            end else begin
                run_q <= 1'b0;
            end
        end
    end

    assign done = run_q && (k_q == '0);
    assign quo  = quo_q;

    logic [DW+SW-1:0] prod_x;
    logic [DW+SW-1:0] dvd_x;
    assign prod_x = {{SW{1'b0}}, quo_q} * {{DW{1'b0}}, dvs_q};
    assign dvd_x  = {{SW{1'b0}}, dvd_q};

    // R3
    quo_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (prod_x <= dvd_x) && ((dvd_x - prod_x) < {{DW{1'b0}}, dvs_q}));
endmodule

// File: rtl/crit_evq.sv
// Pending event set. Captures start/stop pulses while accept is high,
// filters redundant ones and start+stop pairs, and offers the lowest
// pending thread index. Assumes accept and pop are never high together.
module crit_evq #(
    parameter int NT = 4,
    localparam int IW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          pop,
    input  logic [NT-1:0] on_ev,
    input  logic [NT-1:0] off_ev,
    input  logic [NT-1:0] act_mask,
    output logic          any_pend,
    output logic [IW-1:0] sel,
    output logic          sel_on
);
    logic [NT-1:0] pon_q;
    logic [NT-1:0] poff_q;
    logic [NT-1:0] pend;
    logic          found;

    assign pend     = pon_q | poff_q;
    assign any_pend = |pend;

    // Priority pick: the lowest pending index wins.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (pend[i] && !found) begin
                sel   = IW'(i);
                found = 1'b1;
            end
        end
        sel_on = pon_q[sel];
    end

    // Capture filtered pulses when idle; retire the picked entry on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pon_q  <= '0;
            poff_q <= '0;
        end else if (accept) begin
            pon_q  <= on_ev & ~off_ev & ~act_mask;
            poff_q <= off_ev & ~on_ev & act_mask;
        end else if (pop) begin
            pon_q[sel]  <= 1'b0;
            poff_q[sel] <= 1'b0;
        end
    end

    // R7
    pend_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pon_q & act_mask) == '0) && ((poff_q & ~act_mask) == '0));
endmodule

// File: rtl/crit_bank.sv
// Per-thread score registers. Priority per thread: clear, then load,
// then addition of the interval share for threads flagged in add_mask.
// Assumes CW >= TW.
module crit_bank #(
    parameter int NT = 4,
    parameter int CW = 64,
    parameter int TW = 32,
    localparam int IW = $clog2(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_sel,
    input  logic [CW-1:0] ld_val,
    input  logic          add_en,
    input  logic [NT-1:0] add_mask,
    input  logic [TW-1:0] add_val,
    input  logic [IW-1:0] rd_sel,
    output logic [CW-1:0] rd_val
);
    logic [CW-1:0] cnt_q [NT];
    logic [CW-1:0] share;

    assign share  = {{(CW-TW){1'b0}}, add_val};
    assign rd_val = cnt_q[rd_sel];

    for (genvar g = 0; g < NT; g++) begin : g_thr
        logic ld_hit;
        assign ld_hit = ld_en && (ld_sel == IW'(g));

        // Update one thread's score.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cnt_q[g] <= '0;
            end else if (ld_hit) begin
                cnt_q[g] <= ld_val;
            end else if (add_en && add_mask[g]) begin
                cnt_q[g] <= cnt_q[g] + share;
            end
        end

        // R3
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !ld_hit && !add_mask[g]) |=> $stable(cnt_q[g]));

        // R10
        clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (cnt_q[g] == '0));
    end
endmodule

// File: rtl/thread_crit_acc.sv
// Thread criticality accumulator top. Sequences pending events: at service
// start it zeroes the timer and either applies the state change at once (no
// thread working) or starts the divider. When the divider finishes, it adds
// the share to the threads that were working and then updates the flags.
// Assumes NT >= 2 and CW >= TW.
module thread_crit_acc #(
    parameter int NT = 4,
    parameter int CW = 64,
    parameter int TW = 32,
    localparam int IW = $clog2(NT),
    localparam int NW = $clog2(NT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] thr_on_ev,
    input  logic [NT-1:0] thr_off_ev,
    output logic          busy_o,
    output logic [NT-1:0] active_o,
    output logic [NW-1:0] nactive_o,
    input  logic          win_clr,
    input  logic [IW-1:0] rd_sel,
    output logic [CW-1:0] rd_val,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_sel,
    input  logic [CW-1:0] ld_val
);
    import crit_pkg::*;

    localparam int DWW = $clog2(TW + 2);

    svc_state_t    state_q;
    logic [NT-1:0] mask_q;
    logic [NW-1:0] nact_q;
    logic [TW-1:0] timer_q;
    logic [IW-1:0] cur_idx_q;
    logic          cur_on_q;

    logic          any_pend;
    logic [IW-1:0] sel;
    logic          sel_on;
    logic          take;
    logic          div_start;
    logic          div_done;
    logic [TW-1:0] quo;
    logic          apply_div;
    logic          upd_en;
    logic [IW-1:0] upd_idx;
    logic          upd_on;

    assign busy_o    = any_pend || (state_q == SV_DIV);
    assign take      = (state_q == SV_IDLE) && any_pend;
    assign div_start = take && (nact_q != '0);
    assign apply_div = (state_q == SV_DIV) && div_done;
    assign active_o  = mask_q;
    assign nactive_o = nact_q;

    // Select which event, if any, changes the working state this cycle.
    always_comb begin
        upd_en  = (take && (nact_q == '0)) || apply_div;
        upd_idx = apply_div ? cur_idx_q : sel;
        upd_on  = apply_div ? cur_on_q : sel_on;
    end

    crit_evq #(.NT(NT)) evq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (!busy_o),
        .pop      (take),
        .on_ev    (thr_on_ev),
        .off_ev   (thr_off_ev),
        .act_mask (mask_q),
        .any_pend (any_pend),
        .sel      (sel),
        .sel_on   (sel_on)
    );

    crit_div #(.DW(TW), .SW(NW)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_start),
        .dvd_i (timer_q),
        .dvs_i (nact_q),
        .done  (div_done),
        .quo   (quo)
    );

    crit_bank #(.NT(NT), .CW(CW), .TW(TW)) bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (win_clr),
        .ld_en    (ld_en),
        .ld_sel   (ld_sel),
        .ld_val   (ld_val),
        .add_en   (apply_div),
        .add_mask (mask_q),
        .add_val  (quo),
        .rd_sel   (rd_sel),
        .rd_val   (rd_val)
    );

    // Interval timer: zeroed on service start or window clear, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || win_clr || take) begin
            timer_q <= '0;
        end else if (timer_q != '1) begin
            timer_q <= timer_q + 1'b1;
        end
    end

    // Service sequencer and working-state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SV_IDLE;
            mask_q    <= '0;
            nact_q    <= '0;
            cur_idx_q <= '0;
            cur_on_q  <= 1'b0;
        end else begin
            if (take) begin
                cur_idx_q <= sel;
                cur_on_q  <= sel_on;
                if (nact_q != '0) state_q <= SV_DIV;
            end else if (apply_div) begin
                state_q <= SV_IDLE;
            end
            if (upd_en) begin
                mask_q[upd_idx] <= upd_on;
                nact_q          <= upd_on ? nact_q + 1'b1 : nact_q - 1'b1;
            end
        end
    end

    // Cycles spent waiting on the divider, for the latency check.
    logic [DWW-1:0] dwell_q;
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != SV_DIV) dwell_q <= '0;
        else                             dwell_q <= dwell_q + 1'b1;
    end

    // R2
    nact_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nact_q == NW'($countones(mask_q)));

    // R9
    div_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SV_DIV) |-> (dwell_q <= DWW'(TW)));
endmodule

// File: tb/thread_crit_acc_tb.sv
// Directed bench for the thread criticality accumulator.
module thread_crit_acc_tb_top;
    localparam int NT = 4;
    localparam int CW = 64;
    localparam int TW = 16;
    localparam int IW = 2;
    localparam int NW = 3;

    logic          clk;
    logic          rst_n;
    logic [NT-1:0] thr_on_ev;
    logic [NT-1:0] thr_off_ev;
    logic          busy_o;
    logic [NT-1:0] active_o;
    logic [NW-1:0] nactive_o;
    logic          win_clr;
    logic [IW-1:0] rd_sel;
    logic [CW-1:0] rd_val;
    logic          ld_en;
    logic [IW-1:0] ld_sel;
    logic [CW-1:0] ld_val;

    thread_crit_acc #(.NT(NT), .CW(CW), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .thr_on_ev(thr_on_ev), .thr_off_ev(thr_off_ev),
        .busy_o(busy_o), .active_o(active_o), .nactive_o(nactive_o),
        .win_clr(win_clr), .rd_sel(rd_sel), .rd_val(rd_val),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [CW-1:0] m_cnt [NT];
    logic [NT-1:0] m_act;
    int            m_ref;

    task automatic chk_eq(input string req, input logic [CW-1:0] a, input logic [CW-1:0] e);
        n_chk++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    // Apply the requirement rules to a set of captured pulses.
    task automatic model_run(input logic [NT-1:0] on, input logic [NT-1:0] off, input int cap);
        logic [NT-1:0] pon;
        logic [NT-1:0] poff;
        int t;
        int dvd;
        int n;
        pon  = on & ~off & ~m_act;
        poff = off & ~on & m_act;
        t = cap + 1;
        for (int i = 0; i < NT; i++) begin
            if (pon[i] || poff[i]) begin
                dvd   = t - m_ref - 1;
                m_ref = t;
                n     = $countones(m_act);
                if (n != 0) begin
                    for (int j = 0; j < NT; j++)
                        if (m_act[j]) m_cnt[j] = m_cnt[j] + 64'(dvd / n);
                    t = t + TW + 2;
                end else begin
                    t = t + 1;
                end
                m_act[i] = pon[i];
            end
        end
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NT; i++) begin
            rd_sel = IW'(i);
            #1;
            chk_eq(req, rd_val, m_cnt[i]);
        end
        chk_eq(req, 64'(active_o), 64'(m_act));
        chk_eq(req, 64'(nactive_o), 64'($countones(m_act)));
    endtask

    // Present one cycle of pulses once idle, then wait for service to end.
    task automatic post(input logic [NT-1:0] on, input logic [NT-1:0] off);
        int cap;
        while (busy_o) @(negedge clk);
        thr_on_ev  = on;
        thr_off_ev = off;
        @(posedge clk);
        #1 cap = cyc;
        @(negedge clk);
        thr_on_ev  = '0;
        thr_off_ev = '0;
        model_run(on, off, cap);
        while (busy_o) @(negedge clk);
    endtask

    task automatic do_clear();
        win_clr = 1'b1;
        @(posedge clk);
        #1 m_ref = cyc;
        for (int i = 0; i < NT; i++) m_cnt[i] = '0;
        @(negedge clk);
        win_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        chk_eq("R1 busy", 64'(busy_o), 64'd0);
        chk_eq("R1 active", 64'(active_o), 64'd0);
        chk_eq("R1 nactive", 64'(nactive_o), 64'd0);
        for (int i = 0; i < NT; i++) begin
            rd_sel = IW'(i);
            #1;
            chk_eq("R1 score", rd_val, '0);
        end
    endtask

    task automatic t_basic();
        do_clear();
        post(4'b0001, 4'b0000);
        check_all("R5 first start");
        chk_eq("R2 flag", 64'(active_o), 64'h1);
        idle(10);
        post(4'b0010, 4'b0000);
        check_all("R3 single share");
        idle(7);
        post(4'b0000, 4'b0001);
        check_all("R3 split share");
        idle(5);
        post(4'b0000, 4'b0010);
        check_all("R4 interval");
        chk_eq("R2 all idle", 64'(nactive_o), 64'd0);
    endtask

    task automatic t_multi();
        do_clear();
        post(4'b1111, 4'b0000);
        check_all("R6 ascending start");
        idle(4);
        post(4'b0100, 4'b1110);
        check_all("R6 pair ignored");
        chk_eq("R6 thread2 kept", 64'(active_o[2]), 64'd1);
    endtask

    task automatic t_redundant();
        int cap;
        while (busy_o) @(negedge clk);
        thr_on_ev  = 4'b0001;
        thr_off_ev = 4'b1000;
        @(posedge clk);
        #1 cap = cyc;
        @(negedge clk);
        thr_on_ev  = '0;
        thr_off_ev = '0;
        chk_eq("R7 no busy", 64'(busy_o), 64'd0);
        model_run(4'b0001, 4'b1000, cap);
        check_all("R7 no change");
        idle(3);
        post(4'b0000, 4'b0001);
        check_all("R7 timer kept");
    endtask

    task automatic t_busy();
        int cap;
        int n;
        do_clear();
        while (busy_o) @(negedge clk);
        thr_on_ev = 4'b0010;
        @(posedge clk);
        #1 cap = cyc;
        @(negedge clk);
        chk_eq("R8 busy raised", 64'(busy_o), 64'd1);
        thr_on_ev = 4'b1000;
        n = 1;
        @(negedge clk);
        thr_on_ev = '0;
        while (busy_o) begin
            n++;
            @(negedge clk);
        end
        chk_eq("R9 latency", 64'(n), 64'(TW + 2));
        model_run(4'b0010, 4'b0000, cap);
        check_all("R8 held off");
        chk_eq("R8 thread3 idle", 64'(active_o[3]), 64'd0);
    endtask

    task automatic t_load();
        ld_en  = 1'b1;
        ld_sel = 2'd2;
        ld_val = 64'h0123_4567_89AB_CDEF;
        @(negedge clk);
        ld_en = 1'b0;
        m_cnt[2] = 64'h0123_4567_89AB_CDEF;
        rd_sel = 2'd2;
        #1;
        chk_eq("R11 load", rd_val, m_cnt[2]);
        post(4'b0000, 4'b0100);
        check_all("R11 add on loaded");
        ld_en  = 1'b1;
        ld_sel = 2'd1;
        ld_val = 64'd5;
        do_clear();
        ld_en = 1'b0;
        check_all("R10 clear over load");
        idle(6);
        post(4'b0001, 4'b0000);
        check_all("R10 timer zeroed");
    endtask

    initial begin
        rst_n      = 1'b0;
        thr_on_ev  = '0;
        thr_off_ev = '0;
        win_clr    = 1'b0;
        rd_sel     = '0;
        ld_en      = 1'b0;
        ld_sel     = '0;
        ld_val     = '0;
        m_act      = '0;
        m_ref      = 0;
        for (int i = 0; i < NT; i++) m_cnt[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_multi();
        t_redundant();
        t_busy();
        t_load();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule